// File: doc/BRIEF.md
# Streaming ROT13 Payload Transformer

This block sits inline on a 32-bit word stream that carries one UDP datagram at a time, together with its lower-layer header, IP header, UDP header, padding and trailer words. Every payload letter is rotated thirteen places within its own case. Because the rotation is its own inverse, the same block both scrambles and unscrambles a message. All other bytes leave exactly as they arrived, and so does every word outside the payload.

A small framing controller watches the valid strobe and the start-of-frame, end-of-frame and start-of-data flags. From these it works out which words belong to the payload. It takes the byte count from the UDP length field, so the padding bytes in the last payload word are never touched. Each word carries four characters, handled by four byte rotators in parallel. Data and flags come out registered, exactly one cycle later, with no bubbles. The downstream ready signal goes straight back upstream without a register.

Top module: `rot13_stream`

## Requirements
- R1: Within a payload byte that counts, letters 'A'..'M' and 'a'..'m' gain 13 and letters 'N'..'Z' and 'n'..'z' lose 13. For example 'A'->'N', 'M'->'Z', 'N'->'A', 'z'->'m'.
- R2: Payload bytes that are not ASCII letters (for example 0x40, 0x5B, 0x60, 0x7B, digits, spaces) are forwarded unchanged.
- R3: A word holds four characters, the first in bits 31:24 and the fourth in bits 7:0. Each byte is rotated on its own.
- R4: A frame opens on a valid word flagged start-of-frame. Only valid words from the one flagged start-of-data through the one flagged end-of-frame can be altered. The start-of-frame word and all header words pass unchanged.
- R5: The UDP length sits in bits 31:16 of the last valid word before the start-of-data word. The payload byte count is that length minus 8, or 0 if the length is below 8. Payload bytes at or beyond that count, in stream order, are padding and pass unchanged.
- R6: On a cycle with valid low, the data is forwarded unaltered and the framing state does not advance.
- R7: A start-of-data flag on a word outside an open frame (before any start-of-frame, or after end-of-frame) is ignored, and that word passes unchanged.
- R8: Output data, valid, start-of-frame, end-of-frame and start-of-data equal the input values of the previous cycle, with the data transformed as above.
- R9: The upstream ready output equals the downstream ready input in the same cycle.
- R10: While reset is asserted, output data and all output flags are zero.
- R11: Sending an output datagram back through the block restores the original payload; "Hello" becomes "Uryyb" and back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 32 | Input word, first character in the top byte |
| in_valid | input | 1 | Input word valid |
| in_sof | input | 1 | First word of a frame |
| in_eof | input | 1 | Last word of a frame |
| in_sod | input | 1 | First payload word |
| up_ready | output | 1 | Ready returned upstream |
| out_data | output | 32 | Output word |
| out_valid | output | 1 | Output word valid |
| out_sof | output | 1 | Delayed start-of-frame |
| out_eof | output | 1 | Delayed end-of-frame |
| out_sod | output | 1 | Delayed start-of-data |
| dn_ready | input | 1 | Ready from downstream |

## Verification
A framing controller stuck in the wrong state shows up at the ports one cycle after the offending word. It then either scrambles a header word or leaves a payload letter in clear text. A stale or off-by-one byte count appears on the last payload word of the same frame, as a padding byte that was rotated or a final letter that was not. A state that advanced during a valid-low gap corrupts the classification of the next valid word. Random datagrams with random gaps, stray start-of-data flags and extra all-padding words therefore compare every output word against an independently computed value.

// File: rtl/rot13_pkg.sv
package rot13_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HDR  = 2'd1,
      ST_PAY  = 2'd2
   } frame_state_e;

   function automatic logic is_letter(input logic [7:0] b);
      return ((b >= 8'h41) && (b <= 8'h5A)) || ((b >= 8'h61) && (b <= 8'h7A));
   endfunction

endpackage

// File: rtl/rot13_byte.sv
module rot13_byte (
   input  logic       en,
   input  logic [7:0] din,
   output logic [7:0] dout
);
   import rot13_pkg::*;

   logic [4:0] idx;
   logic [4:0] idx_rot;

   // letters share their alphabet position in the low five bits (1..26)
   always_comb begin
      idx     = din[4:0];
      idx_rot = (idx <= 5'd13) ? idx + 5'd13 : idx - 5'd13;
      dout    = (en && is_letter(din)) ? {din[7:5], idx_rot} : din;
   end

endmodule

// File: rtl/rot13_frame_ctl.sv
module rot13_frame_ctl #(
   parameter int LANES     = 4,
   parameter int LEN_W     = 16,
   parameter int HDR_BYTES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sof,
   input  logic             in_eof,
   input  logic             in_sod,
   input  logic [LEN_W-1:0] len_field,
   output logic [LANES-1:0] lane_mask
);
   import rot13_pkg::*;

   localparam logic [LEN_W-1:0] HDR_L   = LEN_W'(HDR_BYTES);
   localparam logic [LEN_W-1:0] LANES_L = LEN_W'(LANES);

   frame_state_e     state_q, state_d;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] rem_q, rem_d, rem_now, rem_after;
   logic             start_pay, in_pay;

   always_comb begin
      start_pay = in_valid && in_sod && !in_sof && (state_q == ST_HDR);
      rem_now   = start_pay ? ((len_q > HDR_L) ? len_q - HDR_L : '0) : rem_q;
      in_pay    = in_valid && !in_sof && (start_pay || (state_q == ST_PAY));
      rem_after = (rem_now > LANES_L) ? rem_now - LANES_L : '0;
      state_d   = state_q;
      rem_d     = rem_q;
      if (in_valid) begin
         if (in_sof) begin
            state_d = in_eof ? ST_IDLE : ST_HDR;
         end else if (in_pay) begin
            rem_d   = rem_after;
            state_d = in_eof ? ST_IDLE : ST_PAY;
         end else if (in_eof) begin
            state_d = ST_IDLE;
         end
      end
   end

   // lane 0 is the first character (top byte)
   for (genvar i = 0; i < LANES; i++) begin : g_mask
      assign lane_mask[i] = in_pay && (rem_now > LEN_W'(i));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rem_q   <= '0;
         len_q   <= '0;
      end else begin
         state_q <= state_d;
         rem_q   <= rem_d;
         if (in_valid) len_q <= len_field;
      end
   end

   // R7
   idle_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> (lane_mask == '0));

   // R5
   pad_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PAY && rem_q == '0) |-> (lane_mask == '0));

   // R6
   gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(state_q) && $stable(rem_q));

endmodule

// File: rtl/rot13_stream.sv
module rot13_stream #(
   parameter int DATA_W    = 32,
   parameter int LEN_W     = 16,
   parameter int LEN_LSB   = 16,
   parameter int HDR_BYTES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   input  logic              in_sof,
   input  logic              in_eof,
   input  logic              in_sod,
   output logic              up_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_valid,
   output logic              out_sof,
   output logic              out_eof,
   output logic              out_sod,
   input  logic              dn_ready
);
   import rot13_pkg::*;

   localparam int LANES = DATA_W / 8;

   if ((DATA_W % 8) != 0 || DATA_W < 8) begin : g_bad_width
      $error("rot13_stream: DATA_W must be a positive multiple of 8");
   end
   if (LEN_LSB + LEN_W > DATA_W) begin : g_bad_len
      $error("rot13_stream: length field exceeds word");
   end

   logic [LANES-1:0]  lane_mask;
   logic [DATA_W-1:0] xf_data;

   rot13_frame_ctl #(
      .LANES     (LANES),
      .LEN_W     (LEN_W),
      .HDR_BYTES (HDR_BYTES)
   ) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_sof    (in_sof),
      .in_eof    (in_eof),
      .in_sod    (in_sod),
      .len_field (in_data[LEN_LSB +: LEN_W]),
      .lane_mask (lane_mask)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      rot13_byte u_rot (
         .en   (lane_mask[i]),
         .din  (in_data[DATA_W-1-8*i -: 8]),
         .dout (xf_data[DATA_W-1-8*i -: 8])
      );

      // R2
      nonalpha_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !is_letter(in_data[DATA_W-1-8*i -: 8]) |=>
            out_data[DATA_W-1-8*i -: 8] == $past(in_data[DATA_W-1-8*i -: 8]));
   end

   assign up_ready = dn_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_data  <= '0;
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
         out_eof   <= 1'b0;
         out_sod   <= 1'b0;
      end else begin
         out_data  <= xf_data;
         out_valid <= in_valid;
         out_sof   <= in_sof;
         out_eof   <= in_eof;
         out_sod   <= in_sod;
      end
   end

   // R8
   valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R8
   flags_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (out_sof == $past(in_sof)) && (out_eof == $past(in_eof))
               && (out_sod == $past(in_sod)));

endmodule

// File: tb/rot13_stream_bench.sv
module rot13_stream_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] in_data;
   logic        in_valid, in_sof, in_eof, in_sod, dn_ready;
   logic        up_ready;
   logic [31:0] out_data;
   logic        out_valid, out_sof, out_eof, out_sod;

   int checks = 0;
   int errors = 0;
   int gap_pct = 0;

   logic [7:0]  pl [0:31];
   int          pl_n;
   logic [31:0] outw [0:7];
   logic [31:0] orig [0:7];

   always #10 clk = ~clk;

   rot13_stream u_rot13_stream (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
      .in_sof(in_sof), .in_eof(in_eof), .in_sod(in_sod), .up_ready(up_ready),
      .out_data(out_data), .out_valid(out_valid), .out_sof(out_sof),
      .out_eof(out_eof), .out_sod(out_sod), .dn_ready(dn_ready)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] rotb(input logic [7:0] b);
      if ((b >= 8'h41 && b <= 8'h4D) || (b >= 8'h61 && b <= 8'h6D)) return b + 8'd13;
      if ((b >= 8'h4E && b <= 8'h5A) || (b >= 8'h6E && b <= 8'h7A)) return b - 8'd13;
      return b;
   endfunction

   // R3: lane i is bits 31-8i..24-8i; rotate lanes with i < nrot
   function automatic logic [31:0] rot_word(input logic [31:0] w, input int nrot);
      logic [31:0] r = w;
      for (int i = 0; i < 4; i++)
         if (i < nrot) r[31-8*i -: 8] = rotb(w[31-8*i -: 8]);
      return r;
   endfunction

   // drive at a falling edge, check the registered result at the next one (R8)
   task automatic step(input logic [31:0] d, input logic v, input logic sof,
                       input logic eof, input logic sod,
                       input logic [31:0] exp_d, input string tag);
      in_data = d; in_valid = v; in_sof = sof; in_eof = eof; in_sod = sod;
      dn_ready = 1'($urandom_range(0, 1));
      #1;
      chk("R9 up_ready", {31'd0, up_ready}, {31'd0, dn_ready});
      @(negedge clk);
      chk(tag, out_data, exp_d);
      chk("R8 valid", {31'd0, out_valid}, {31'd0, v});
      chk("R8 flags", {29'd0, out_sof, out_eof, out_sod}, {29'd0, sof, eof, sod});
   endtask

   task automatic maybe_gap();
      logic [31:0] g;
      if ($urandom_range(0, 99) < gap_pct) begin
         g = $urandom;
         step(g, 1'b0, 1'b0, 1'b0, 1'($urandom_range(0, 1)), g, "R6 gap");
      end
   endtask

   task automatic send_frame(input int len_field, input int extra_pad);
      logic [31:0] w;
      int nrot, nwords;
      nrot   = (len_field > 8) ? len_field - 8 : 0;
      nwords = (pl_n + 3) / 4;
      if (nwords == 0) nwords = 1;
      nwords += extra_pad;
      for (int j = pl_n; j < 32; j++) pl[j] = 8'($urandom);
      w = $urandom;
      step(w, 1'b1, 1'b1, 1'b0, 1'b0, w, "R4 sof word");
      for (int k = 0; k < 6; k++) begin
         maybe_gap();
         w = $urandom;
         step(w, 1'b1, 1'b0, 1'b0, 1'b0, w, "R4 header");
      end
      maybe_gap();
      w = {16'(len_field), 16'($urandom)};
      step(w, 1'b1, 1'b0, 1'b0, 1'b0, w, "R4 length word");
      for (int k = 0; k < nwords; k++) begin
         maybe_gap();
         w = {pl[4*k], pl[4*k+1], pl[4*k+2], pl[4*k+3]};
         step(w, 1'b1, 1'b0, 1'(k == nwords - 1), 1'(k == 0),
              rot_word(w, nrot - 4*k), "R1 R5 payload");
         outw[k] = out_data;
         orig[k] = w;
      end
      maybe_gap();
      w = $urandom;
      w[31:24] = 8'h61;
      step(w, 1'b1, 1'b0, 1'b0, 1'b1, w, "R7 stray sod");
   endtask

   task automatic load_str(input logic [31:0] a, input logic [31:0] b, input int n);
      for (int i = 0; i < 4; i++) begin
         pl[i]   = a[31-8*i -: 8];
         pl[4+i] = b[31-8*i -: 8];
      end
      pl_n = n;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd5310));
      rst_n = 1'b0; in_data = 32'hFFFF_FFFF; in_valid = 1'b1;
      in_sof = 1'b1; in_eof = 1'b1; in_sod = 1'b1; dn_ready = 1'b0;
      repeat (2) @(negedge clk);
      chk("R10 reset data", out_data, 32'd0);
      chk("R10 reset flags", {28'd0, out_valid, out_sof, out_eof, out_sod}, 32'd0);
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_sod = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      // R7: stray start-of-data before any frame
      step(32'h4142_6162, 1'b1, 1'b0, 1'b0, 1'b1, 32'h4142_6162, "R7 sod before frame");

      // R1 boundaries and R2 non-letters: len 20 -> 12 payload bytes
      load_str(32'h414D_4E5A, 32'h616D_6E7A, 8);
      pl[8] = 8'h40; pl[9] = 8'h5B; pl[10] = 8'h60; pl[11] = 8'h7B; pl_n = 12;
      send_frame(20, 0);
      chk("R1 upper bounds", outw[0], 32'h4E5A_414D);
      chk("R1 lower bounds", outw[1], 32'h6E7A_616D);
      chk("R2 non-letters", outw[2], 32'h405B_607B);

      // R11: "Hello" -> "Uryyb" -> "Hello", padding 'xyz' kept (R5)
      load_str(32'h4865_6C6C, 32'h6F78_797A, 8);
      send_frame(13, 0);
      chk("R11 Hell->Uryy", outw[0], 32'h5572_7979);
      chk("R5 o+pad->b+pad", outw[1], 32'h6278_797A);
      load_str(outw[0], outw[1], 8);
      send_frame(13, 0);
      chk("R11 back Hell", outw[0], 32'h4865_6C6C);
      chk("R11 back o+pad", outw[1], 32'h6F78_797A);

      // R5: short length, and a partial word
      load_str(32'h6162_6364, 32'h0, 4);
      send_frame(4, 0);
      chk("R5 length below 8", outw[0], 32'h6162_6364);
      load_str(32'h6162_6364, 32'h0, 4);
      send_frame(10, 1);
      chk("R5 two bytes", outw[0], 32'h6E6F_6364);

      // random datagrams with gaps and extra padding words
      gap_pct = 30;
      for (int f = 0; f < 60; f++) begin
         pl_n = $urandom_range(0, 20);
         for (int j = 0; j < pl_n; j++)
            pl[j] = ($urandom_range(0, 3) != 0) ? 8'($urandom_range(8'h41, 8'h7A))
                                                : 8'($urandom);
         send_frame(8 + pl_n, $urandom_range(0, 1));
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule